// File: doc/BRIEF.md
# CAN Controller Mode and Power-Save Register

This block holds the operating state of a CAN controller as software sees it. It keeps a three-bit operation-mode field, a two-bit power-save field and three general status flags, all written through one register word. The three flags are written with set/clear bit pairs, so software can change one flag without reading the register first. The operation-mode and power-save fields are written as a code plus an update-enable bit.

The block accepts only legal mode changes. It drops prohibited codes. It reaches stop mode only through sleep mode. It freezes the operation mode while any power-save mode is active. A sleep request waits as a pending flag until the controller core reports an idle bus. The readback word always shows the mode that is actually in effect, together with the pending flag and a buffer-access-ready flag. That ready flag drops on every exit from power save and comes back only when the core signals that its message buffers are ready.

Top module: `can_mode_ctl`

## Requirements
- R1: Reset (synchronous, active high) clears the whole readback word. That means operation mode 000 (initialization), power save 00, no pending sleep, buffer-ready flag 0 and all three flags 0.
- R2: Write word bits [9:7] are set bits and bits [12:10] are clear bits for flags 0..2. For each flag: set=1 and clear=0 sets it, set=0 and clear=1 clears it, and any other combination leaves it unchanged. The change is visible one cycle after the write.
- R3: A write with bit [3]=1 loads operation-mode code [2:0] into readback bits [2:0] one cycle later. The codes are 000 init, 001 normal, 010 normal with automatic block send, 011 receive-only, 100 single-shot, 101 self-test.
- R4: An operation-mode write with code 110 or 111 is ignored, and the previous code is kept.
- R5: While power save (readback bits [4:3]) is sleep 01 or stop 11, operation-mode writes have no effect.
- R6: A power-save write (bit [6]=1, code in [5:4]) of 01 from no-power-save sets the pending flag (readback bit 5). The power save reads 00 until a later cycle in which bus_idle is high. In that cycle it becomes 01 and the pending flag clears.
- R7: A power-save write of 00 while sleep is pending drops the pending flag and leaves the mode at 00. This holds even if bus_idle is high in the same cycle.
- R8: Stop mode 11 is entered only from sleep and is left only to sleep. A request for 11 from 00, or for 00 from 11, is ignored. From sleep, a write of 00 returns to no power save.
- R9: A power-save write with the prohibited code 10 is ignored.
- R10: The buffer-ready flag (readback bit 6) clears in the cycle after power save is left, whatever buf_ready is. While power save is 00 it is set one cycle after buf_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 13 | Write word: [2:0] op code, [3] op update, [5:4] power-save code, [6] power-save update, [9:7] flag set, [12:10] flag clear |
| bus_idle | input | 1 | The controller core reports the CAN bus idle |
| buf_ready | input | 1 | The controller core reports its message buffers accessible |
| rd_data | output | 10 | Readback: [2:0] active op mode, [4:3] active power save, [5] sleep pending, [6] buffer ready, [9:7] flags |

## Verification
The checker watches several invariants on every cycle. The readback never shows a prohibited operation or power-save code. The operation mode stays frozen during power save. Stop mode is never reached from, or left to, no-power-save. No sleep entry happens in a cycle without bus idle. The buffer-ready flag is low right after any exit from power save. Flag set/clear results are also checked against the previous write. The bench scenarios cover the things that need ordered sequences: a sleep request waiting through busy cycles and then being cancelled, a cancel that lands in the same cycle as bus idle, the full sleep–stop–sleep–exit round trip with the ready flag's priority over the core input, and reset taking effect from a busy state.

// File: rtl/can_mctl_pkg.sv
package can_mctl_pkg;

    localparam int FLAG_N = 3;
    localparam int OP_W   = 3;
    localparam int PS_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_INIT     = 3'd0,
        OP_NORMAL   = 3'd1,
        OP_NORM_BLK = 3'd2,
        OP_RX_ONLY  = 3'd3,
        OP_ONE_SHOT = 3'd4,
        OP_SELFTEST = 3'd5
    } op_mode_e;

    localparam logic [OP_W-1:0] OP_LAST_LEGAL = OP_SELFTEST;

    typedef enum logic [PS_W-1:0] {
        PS_NONE  = 2'b00,
        PS_SLEEP = 2'b01,
        PS_BAD   = 2'b10,
        PS_STOP  = 2'b11
    } ps_mode_e;

    // Write word layout, MSB first
    typedef struct packed {
        logic [FLAG_N-1:0] clr;
        logic [FLAG_N-1:0] set;
        logic              ps_we;
        logic [PS_W-1:0]   ps;
        logic              op_we;
        logic [OP_W-1:0]   op;
    } wr_cmd_t;

    // Readback word layout, MSB first
    typedef struct packed {
        logic [FLAG_N-1:0] flags;
        logic              buf_ok;
        logic              pend;
        logic [PS_W-1:0]   ps;
        logic [OP_W-1:0]   op;
    } rd_word_t;

    localparam int WR_W = $bits(wr_cmd_t);
    localparam int RD_W = $bits(rd_word_t);

    function automatic logic op_code_ok(input logic [OP_W-1:0] code);
        return code <= OP_LAST_LEGAL;
    endfunction

    function automatic wr_cmd_t gate_cmd(input logic [WR_W-1:0] d, input logic en);
        wr_cmd_t c;
        c       = wr_cmd_t'(d);
        c.op_we = c.op_we & en;
        c.ps_we = c.ps_we & en;
        c.set   = c.set & {FLAG_N{en}};
        c.clr   = c.clr & {FLAG_N{en}};
        return c;
    endfunction

endpackage

// File: rtl/mctl_flags.sv
module mctl_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q_n;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign q_n[i] = (set_i[i] & ~clr_i[i]) ? 1'b1 :
                        (clr_i[i] & ~set_i[i]) ? 1'b0 : q_o[i];
    end

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= q_n;
    end
endmodule

// File: rtl/mctl_opmode.sv
module mctl_opmode
    import can_mctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we_i,
    input  logic [OP_W-1:0] code_i,
    input  logic            lock_i,
    output logic [OP_W-1:0] op_o
);
    logic take;
    assign take = we_i && !lock_i && op_code_ok(code_i);

    always_ff @(posedge clk) begin
        if (rst)       op_o <= OP_INIT;
        else if (take) op_o <= code_i;
    end
endmodule

// File: rtl/mctl_psave.sv
module mctl_psave
    import can_mctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  ps_mode_e req_i,
    input  logic     bus_idle_i,
    input  logic     core_rdy_i,
    output ps_mode_e ps_o,
    output logic     pend_o,
    output logic     buf_ok_o
);
    ps_mode_e ps_n;
    logic     pend_n;
    logic     leave;

    always_comb begin
        ps_n   = ps_o;
        pend_n = pend_o;
        leave  = 1'b0;
        if (we_i) begin
            unique case (ps_o)
                PS_NONE: begin
                    if (req_i == PS_SLEEP)     pend_n = 1'b1;
                    else if (req_i == PS_NONE) pend_n = 1'b0;
                end
                PS_SLEEP: begin
                    if (req_i == PS_STOP) begin
                        ps_n = PS_STOP;
                    end else if (req_i == PS_NONE) begin
                        ps_n  = PS_NONE;
                        leave = 1'b1;
                    end
                end
                PS_STOP: begin
                    if (req_i == PS_SLEEP) ps_n = PS_SLEEP;
                end
                default: ps_n = PS_NONE;
            endcase
        end
        // A request already registered commits once the bus is idle
        if (ps_o == PS_NONE && pend_o && pend_n && bus_idle_i) begin
            ps_n   = PS_SLEEP;
            pend_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_o     <= PS_NONE;
            pend_o   <= 1'b0;
            buf_ok_o <= 1'b0;
        end else begin
            ps_o   <= ps_n;
            pend_o <= pend_n;
            if (leave)                               buf_ok_o <= 1'b0;
            else if (ps_o == PS_NONE && core_rdy_i)  buf_ok_o <= 1'b1;
        end
    end
endmodule

// File: rtl/can_mode_ctl.sv
module can_mode_ctl
    import can_mctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            bus_idle,
    input  logic            buf_ready,
    output logic [RD_W-1:0] rd_data
);
    wr_cmd_t           cmd;
    ps_mode_e          ps_q;
    logic              pend_q;
    logic              buf_ok_q;
    logic [OP_W-1:0]   op_q;
    logic [FLAG_N-1:0] flags_q;
    rd_word_t          rd;

    assign cmd = gate_cmd(wr_data, wr_en);

    mctl_flags #(.N(FLAG_N)) i_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (cmd.set),
        .clr_i (cmd.clr),
        .q_o   (flags_q)
    );

    mctl_opmode i_opmode (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cmd.op_we),
        .code_i (cmd.op),
        .lock_i (ps_q != PS_NONE),
        .op_o   (op_q)
    );

    mctl_psave i_psave (
        .clk        (clk),
        .rst        (rst),
        .we_i       (cmd.ps_we),
        .req_i      (ps_mode_e'(cmd.ps)),
        .bus_idle_i (bus_idle),
        .core_rdy_i (buf_ready),
        .ps_o       (ps_q),
        .pend_o     (pend_q),
        .buf_ok_o   (buf_ok_q)
    );

    always_comb begin
        rd.flags  = flags_q;
        rd.buf_ok = buf_ok_q;
        rd.pend   = pend_q;
        rd.ps     = ps_q;
        rd.op     = op_q;
    end

    assign rd_data = rd;
endmodule

// File: rtl/can_mode_ctl_chk.sv
module can_mode_ctl_chk
    import can_mctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [WR_W-1:0] wr_data,
    input logic            bus_idle,
    input logic [RD_W-1:0] rd_data
);
    rd_word_t          r;
    wr_cmd_t           w;
    logic [FLAG_N-1:0] set_only;
    logic [FLAG_N-1:0] clr_only;

    assign r        = rd_word_t'(rd_data);
    assign w        = wr_cmd_t'(wr_data);
    assign set_only = wr_en ? (w.set & ~w.clr) : '0;
    assign clr_only = wr_en ? (w.clr & ~w.set) : '0;

    p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
        (set_only != '0) |=> ((r.flags & $past(set_only)) == $past(set_only)));

    p_flag_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_only != '0) |=> ((r.flags & $past(clr_only)) == '0));

    p_op_legal_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> op_code_ok(r.op));

    p_op_lock_r5: assert property (@(posedge clk) disable iff (rst)
        (r.ps != PS_NONE) |=> (r.op == $past(r.op)));

    p_sleep_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (r.ps == PS_NONE && !bus_idle) |=> (r.ps == PS_NONE));

    p_no_stop_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (r.ps == PS_NONE) |=> (r.ps != PS_STOP));

    p_no_stop_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (r.ps == PS_STOP) |=> (r.ps != PS_NONE));

    p_ps_legal_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (r.ps != PS_BAD));

    p_buf_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (r.ps != PS_NONE) |=> (r.ps != PS_NONE || !r.buf_ok));
endmodule

bind can_mode_ctl can_mode_ctl_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .bus_idle (bus_idle),
    .rd_data  (rd_data)
);

// File: tb/test_can_mode_ctl.sv
module test_can_mode_ctl;
    import can_mctl_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [WR_W-1:0] wr_data = '0;
    logic            bus_idle = 1'b0;
    logic            buf_ready = 1'b0;
    logic [RD_W-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    can_mode_ctl i_can_mode_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .bus_idle  (bus_idle),
        .buf_ready (buf_ready),
        .rd_data   (rd_data)
    );

    // write word: {clr, set, ps_we, ps, op_we, op}
    function automatic logic [12:0] mw(input logic ow, input logic [2:0] op,
                                       input logic pw, input logic [1:0] ps,
                                       input logic [2:0] st, input logic [2:0] cl);
        return {cl, st, pw, ps, ow, op};
    endfunction

    // readback: {flags, buf_ok, pend, ps, op}
    function automatic logic [9:0] mr(input logic [2:0] op, input logic [1:0] ps,
                                      input logic pd, input logic rd, input logic [2:0] fl);
        return {fl, rd, pd, ps, op};
    endfunction

    typedef struct packed {
        logic        wr;
        logic [12:0] wd;
        logic        idle;
        logic        crdy;
        logic [9:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 13'd0,                         1'b0, 1'b1, mr(0,0,0,1,0), 4'd10}, // R10 ready sets
        '{1'b1, mw(1,1,0,0,0,0),               1'b0, 1'b1, mr(1,0,0,1,0), 4'd3},  // R3 normal
        '{1'b1, mw(1,6,0,0,0,0),               1'b0, 1'b1, mr(1,0,0,1,0), 4'd4},  // R4 code 110
        '{1'b1, mw(1,7,0,0,0,0),               1'b0, 1'b1, mr(1,0,0,1,0), 4'd4},  // R4 code 111
        '{1'b1, mw(0,0,0,0,3'b101,3'b000),     1'b0, 1'b1, mr(1,0,0,1,5), 4'd2},  // R2 set
        '{1'b1, mw(0,0,0,0,3'b011,3'b110),     1'b0, 1'b1, mr(1,0,0,1,1), 4'd2},  // R2 mixed pairs
        '{1'b1, mw(0,0,1,3,0,0),               1'b0, 1'b1, mr(1,0,0,1,1), 4'd8},  // R8 none->stop
        '{1'b1, mw(0,0,1,2,0,0),               1'b0, 1'b1, mr(1,0,0,1,1), 4'd9},  // R9 code 10
        '{1'b1, mw(0,0,1,1,0,0),               1'b0, 1'b1, mr(1,0,1,1,1), 4'd6},  // R6 pending
        '{1'b0, 13'd0,                         1'b0, 1'b1, mr(1,0,1,1,1), 4'd6},  // R6 still busy
        '{1'b1, mw(0,0,1,0,0,0),               1'b0, 1'b1, mr(1,0,0,1,1), 4'd7},  // R7 cancel
        '{1'b1, mw(0,0,1,1,0,0),               1'b0, 1'b1, mr(1,0,1,1,1), 4'd6},  // R6 request again
        '{1'b0, 13'd0,                         1'b1, 1'b1, mr(1,1,0,1,1), 4'd6},  // R6 idle -> sleep
        '{1'b1, mw(1,3,0,0,0,0),               1'b1, 1'b1, mr(1,1,0,1,1), 4'd5},  // R5 locked in sleep
        '{1'b1, mw(0,0,1,3,0,0),               1'b1, 1'b1, mr(1,3,0,1,1), 4'd8},  // R8 sleep->stop
        '{1'b1, mw(0,0,1,0,0,0),               1'b1, 1'b1, mr(1,3,0,1,1), 4'd8},  // R8 stop->none blocked
        '{1'b1, mw(1,2,0,0,0,0),               1'b1, 1'b1, mr(1,3,0,1,1), 4'd5},  // R5 locked in stop
        '{1'b1, mw(0,0,1,1,0,0),               1'b1, 1'b1, mr(1,1,0,1,1), 4'd8},  // R8 stop->sleep
        '{1'b1, mw(0,0,1,0,0,0),               1'b1, 1'b1, mr(1,0,0,0,1), 4'd10}, // R10 exit clears
        '{1'b0, 13'd0,                         1'b1, 1'b0, mr(1,0,0,0,1), 4'd10}, // R10 waits
        '{1'b0, 13'd0,                         1'b1, 1'b1, mr(1,0,0,1,1), 4'd10}, // R10 returns
        '{1'b1, mw(1,5,0,0,0,0),               1'b1, 1'b1, mr(5,0,0,1,1), 4'd3},  // R3 self-test
        '{1'b1, mw(0,0,1,1,0,0),               1'b0, 1'b1, mr(5,0,1,1,1), 4'd6},  // R6 pending
        '{1'b1, mw(0,0,1,0,0,0),               1'b1, 1'b1, mr(5,0,0,1,1), 4'd7},  // R7 cancel beats idle
        '{1'b0, 13'd0,                         1'b1, 1'b1, mr(5,0,0,1,1), 4'd7}   // R7 stays out
    };

    task automatic check(input string tag, input logic [9:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 initial reset", 10'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            wr_en     = VEC[i].wr;
            wr_data   = VEC[i].wd;
            bus_idle  = VEC[i].idle;
            buf_ready = VEC[i].crdy;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp);
        end

        // R1: reset from a busy state with flags set and self-test mode
        wr_en = 1'b0; buf_ready = 1'b0; bus_idle = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset from active state", 10'd0);
        rst = 1'b0;

        // R2: both bits of a pair set leaves every flag unchanged
        wr_en = 1'b1; wr_data = mw(0,0,0,0,3'b110,3'b000);
        @(negedge clk);
        check("R2 set flags 1,2", mr(0,0,0,0,3'b110));
        wr_data = mw(0,0,0,0,3'b111,3'b111);
        @(negedge clk);
        check("R2 both set and clear", mr(0,0,0,0,3'b110));
        wr_en = 1'b0; wr_data = mw(0,0,0,0,3'b000,3'b111);
        @(negedge clk);
        check("R2 no strobe no change", mr(0,0,0,0,3'b110));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule